// File: doc/BRIEF.md
# Full-Search Block-Matching SAD Engine

This block performs an exhaustive motion search for one 8×8 block of unsigned 8-bit pixels. A square reference area of 40×40 pixels, centred on a single predicted position, is written into the engine one row per write through a wide data word. The current block is written as eight 64-bit rows. It is held in registers and reused for every candidate. Only this one area is searched. No other candidate positions are visited.

After both stores are filled, a start pulse makes the engine visit all 33×33 = 1089 candidate offsets, from −16 to +16 in each direction. It issues one offset per clock into a pipelined tree that sums the 64 absolute differences. A running minimum records the smallest sum and its offset. A one-cycle done pulse marks the cycle from which the lowest SAD and its signed motion vector can be read. Every candidate is always evaluated, and no search is ended early.

Top module: `me_fullsearch`

## Requirements
- R1: Window row word `winData` bits [8c+7:8c] hold the pixel at column c of row `winRow` (0..39). Current-block word `curData` bits [8c+7:8c] hold column c of row `curRow` (0..7). For offset (dx,dy), current pixel (r,c) is compared with window pixel (r+dy+16, c+dx+16).
- R2: A start pulse is ignored, and busy stays low, until all 40 window rows and all 8 current rows have been written since reset.
- R3: An accepted search evaluates all 1089 offsets. It reports in `bestSad` the smallest SAD, where SAD is the sum over 64 pixels of |cur − ref|.
- R4: `mvX`/`mvY` give the dx/dy of the winning offset as 6-bit two's-complement values in −16..+16.
- R5: Offsets are scanned with dy as the outer loop and dx as the inner loop, each from −16 upward. On equal SAD, the offset met first in this order is kept.
- R6: `done` is high for exactly one cycle. It rises 1091 clock cycles after the edge that accepted start (1089 issues plus two pipeline stages).
- R7: `busy` is high from the cycle after an accepted start up to and including the done cycle. A start while busy is ignored.
- R8: Row writes to either store while busy are ignored.
- R9: Each accepted start clears the running minimum, so a result never depends on an earlier search. The largest possible SAD of 16320 is reported exactly.
- R10: `bestSad`, `mvX` and `mvY` hold their values from the done cycle until the next accepted start.
- R11: After reset, `busy` and `done` are 0, `bestSad` is 16383 (all ones), and `mvX` and `mvY` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curWe | input | 1 | Current-block row write strobe |
| curRow | input | 3 | Current-block row index |
| curData | input | 64 | Eight packed current pixels |
| winWe | input | 1 | Window row write strobe |
| winRow | input | 6 | Window row index (0..39) |
| winData | input | 320 | Forty packed window pixels |
| start | input | 1 | Begin a search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| bestSad | output | 14 | Lowest SAD found |
| mvX | output | 6 | Signed horizontal offset of the best match |
| mvY | output | 6 | Signed vertical offset of the best match |

## Verification
The only result that arrives late is the done strobe with its three result values. It is due 1091 cycles after the start edge. The bench records the cycle count when it raises start, and a monitor compares the elapsed count when done appears, so an early, late or extra strobe is reported. The bench samples every output on the falling clock edge. Busy is checked one cycle after start. Result stability is checked ten cycles after busy falls. The start pulse with an incomplete window load is followed by several idle cycles, during which busy must stay low.

// File: rtl/me_search_pkg.sv
package me_search_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SCAN  = 2'd1,
    S_DRAIN = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic issue;
    logic clrMin;
    logic isLast;
  } searchStrb_t;

endpackage

// File: rtl/me_search_ctrl.sv
module me_search_ctrl
  import me_search_pkg::*;
#(
  parameter int RANGE = 16,
  localparam int SPAN  = 2 * RANGE + 1,
  localparam int OFF_W = $clog2(SPAN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             allLoaded,
  input  logic             dpDone,
  output searchStrb_t      strb,
  output logic [OFF_W-1:0] posX,
  output logic [OFF_W-1:0] posY,
  output logic             busy
);

  localparam logic [OFF_W-1:0] MAXP = OFF_W'(SPAN - 1);

  ctrlState_e state;
  logic accept;
  logic atLast;

  assign accept = (state == S_IDLE) && start && allLoaded;
  assign atLast = (posX == MAXP) && (posY == MAXP);

  always_comb begin
    strb.issue  = (state == S_SCAN);
    strb.clrMin = accept;
    strb.isLast = (state == S_SCAN) && atLast;
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      posX  <= '0;
      posY  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            state <= S_SCAN;
            posX  <= '0;
            posY  <= '0;
          end
        end
        S_SCAN: begin
          if (atLast) begin
            state <= S_DRAIN;
          end else if (posX == MAXP) begin
            posX <= '0;
            posY <= posY + 1'b1;
          end else begin
            posX <= posX + 1'b1;
          end
        end
        S_DRAIN: begin
          if (dpDone) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: the datapath may only finish while the scan is draining
  assert_done_in_drain_R6: assert property (@(posedge clk) disable iff (!rstN)
    dpDone |-> (state == S_DRAIN));

  // R5: raster order, dx steps by one inside a row of offsets
  assert_raster_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SCAN && posX != MAXP) |=>
      (posX == $past(posX) + 1'b1) && (posY == $past(posY)));

endmodule

// File: rtl/me_search_dp.sv
module me_search_dp
  import me_search_pkg::*;
#(
  parameter int BLK   = 8,
  parameter int RANGE = 16,
  parameter int PIX_W = 8,
  localparam int WIN       = BLK + 2 * RANGE,
  localparam int ROW_W     = WIN * PIX_W,
  localparam int CUR_W     = BLK * PIX_W,
  localparam int SPAN      = 2 * RANGE + 1,
  localparam int OFF_W     = $clog2(SPAN),
  localparam int WIN_IDX_W = $clog2(WIN),
  localparam int CUR_IDX_W = $clog2(BLK),
  localparam int PIX_MAX   = (1 << PIX_W) - 1,
  localparam int SAD_MAX   = BLK * BLK * PIX_MAX,
  localparam int SAD_W     = $clog2(SAD_MAX + 1),
  localparam int RSUM_W    = $clog2(BLK * PIX_MAX + 1),
  localparam int SH_W      = $clog2(ROW_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  searchStrb_t             strb,
  input  logic [OFF_W-1:0]        posX,
  input  logic [OFF_W-1:0]        posY,
  input  logic                    busy,
  input  logic                    curWe,
  input  logic [CUR_IDX_W-1:0]    curRow,
  input  logic [CUR_W-1:0]        curData,
  input  logic                    winWe,
  input  logic [WIN_IDX_W-1:0]    winRow,
  input  logic [ROW_W-1:0]        winData,
  output logic                    allLoaded,
  output logic                    done,
  output logic [SAD_W-1:0]        bestSad,
  output logic signed [OFF_W-1:0] mvX,
  output logic signed [OFF_W-1:0] mvY
);

  // ---------------- pixel stores ----------------
  logic [ROW_W-1:0] winMem [WIN];
  logic [CUR_W-1:0] curMem [BLK];
  logic [WIN-1:0]   winLoaded;
  logic [BLK-1:0]   curLoaded;
  logic             winWrOk;

  assign winWrOk = winWe && !busy && (winRow < WIN_IDX_W'(WIN));

  always_ff @(posedge clk) begin
    if (winWrOk) winMem[winRow] <= winData;
    if (curWe && !busy) curMem[curRow] <= curData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winLoaded <= '0;
      curLoaded <= '0;
    end else begin
      if (winWrOk) winLoaded[winRow] <= 1'b1;
      if (curWe && !busy) curLoaded[curRow] <= 1'b1;
    end
  end

  assign allLoaded = (&winLoaded) && (&curLoaded);

  // ---------------- stage 1: per-row absolute difference sums ----------------
  logic [SH_W-1:0]   shAmt;
  logic [RSUM_W-1:0] rowSumD [BLK];
  logic [RSUM_W-1:0] rowSumQ [BLK];

  assign shAmt = SH_W'(posX) * SH_W'(PIX_W);

  for (genvar r = 0; r < BLK; r++) begin : g_row
    logic [WIN_IDX_W-1:0] rIdx;
    logic [ROW_W-1:0]     shifted;
    logic [CUR_W-1:0]     refSeg;

    assign rIdx    = WIN_IDX_W'(posY) + WIN_IDX_W'(r);
    assign shifted = winMem[rIdx] >> shAmt;
    assign refSeg  = shifted[CUR_W-1:0];

    always_comb begin
      logic [PIX_W-1:0] pa;
      logic [PIX_W-1:0] pb;
      rowSumD[r] = '0;
      for (int c = 0; c < BLK; c++) begin
        pa = curMem[r][c*PIX_W +: PIX_W];
        pb = refSeg[c*PIX_W +: PIX_W];
        rowSumD[r] = rowSumD[r] + RSUM_W'((pa > pb) ? (pa - pb) : (pb - pa));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.issue) begin
      for (int r = 0; r < BLK; r++) rowSumQ[r] <= rowSumD[r];
    end
  end

  // ---------------- stage 2: block total ----------------
  logic [SAD_W-1:0] totalD;
  logic [SAD_W-1:0] sumQ;

  always_comb begin
    totalD = '0;
    for (int r = 0; r < BLK; r++) totalD = totalD + SAD_W'(rowSumQ[r]);
  end

  logic             v1, v2, last1, last2;
  logic [OFF_W-1:0] p1x, p1y, p2x, p2y;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1    <= 1'b0;
      v2    <= 1'b0;
      last1 <= 1'b0;
      last2 <= 1'b0;
      p1x   <= '0;
      p1y   <= '0;
      p2x   <= '0;
      p2y   <= '0;
      sumQ  <= '0;
    end else begin
      v1    <= strb.issue;
      last1 <= strb.isLast;
      p1x   <= posX;
      p1y   <= posY;
      v2    <= v1;
      last2 <= last1;
      p2x   <= p1x;
      p2y   <= p1y;
      if (v1) sumQ <= totalD;
    end
  end

  // ---------------- stage 3: running minimum ----------------
  logic [OFF_W-1:0] bestX, bestY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestSad <= '1;
      bestX   <= OFF_W'(RANGE);
      bestY   <= OFF_W'(RANGE);
      done    <= 1'b0;
    end else begin
      done <= v2 && last2;
      if (strb.clrMin) begin
        bestSad <= '1;
        bestX   <= OFF_W'(RANGE);
        bestY   <= OFF_W'(RANGE);
      end else if (v2 && (sumQ < bestSad)) begin
        bestSad <= sumQ;
        bestX   <= p2x;
        bestY   <= p2y;
      end
    end
  end

  assign mvX = $signed(bestX - OFF_W'(RANGE));
  assign mvY = $signed(bestY - OFF_W'(RANGE));

  // R3: the minimum can never grow while a scan result is folded in
  assert_min_monotonic_R3: assert property (@(posedge clk) disable iff (!rstN)
    (v2 && !strb.clrMin) |=> (bestSad <= $past(bestSad)));

  // R6: the result strobe lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a block total never exceeds the largest representable SAD
  assert_sad_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    v2 |-> (sumQ <= SAD_W'(SAD_MAX)));

  // R10: results stay put when nothing is being scanned or restarted
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!v2 && !strb.clrMin) |=> ($stable(bestSad) && $stable(bestX) && $stable(bestY)));

endmodule

// File: rtl/me_fullsearch.sv
module me_fullsearch
  import me_search_pkg::*;
#(
  parameter int BLK   = 8,
  parameter int RANGE = 16,
  parameter int PIX_W = 8,
  localparam int WIN       = BLK + 2 * RANGE,
  localparam int ROW_W     = WIN * PIX_W,
  localparam int CUR_W     = BLK * PIX_W,
  localparam int OFF_W     = $clog2(2 * RANGE + 1),
  localparam int WIN_IDX_W = $clog2(WIN),
  localparam int CUR_IDX_W = $clog2(BLK),
  localparam int SAD_W     = $clog2(BLK * BLK * ((1 << PIX_W) - 1) + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    curWe,
  input  logic [CUR_IDX_W-1:0]    curRow,
  input  logic [CUR_W-1:0]        curData,
  input  logic                    winWe,
  input  logic [WIN_IDX_W-1:0]    winRow,
  input  logic [ROW_W-1:0]        winData,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [SAD_W-1:0]        bestSad,
  output logic signed [OFF_W-1:0] mvX,
  output logic signed [OFF_W-1:0] mvY
);

  searchStrb_t      strb;
  logic [OFF_W-1:0] posX, posY;
  logic             allLoaded;

  me_search_ctrl #(.RANGE(RANGE)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .allLoaded (allLoaded),
    .dpDone    (done),
    .strb      (strb),
    .posX      (posX),
    .posY      (posY),
    .busy      (busy)
  );

  me_search_dp #(.BLK(BLK), .RANGE(RANGE), .PIX_W(PIX_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .posX      (posX),
    .posY      (posY),
    .busy      (busy),
    .curWe     (curWe),
    .curRow    (curRow),
    .curData   (curData),
    .winWe     (winWe),
    .winRow    (winRow),
    .winData   (winData),
    .allLoaded (allLoaded),
    .done      (done),
    .bestSad   (bestSad),
    .mvX       (mvX),
    .mvY       (mvY)
  );

endmodule

// File: tb/me_fullsearch_tb_top.sv
`timescale 1ns/1ps
module me_fullsearch_tb_top;

  localparam int BLK = 8;
  localparam int RNG = 16;
  localparam int WIN = 40;
  localparam int LAT = 1092; // bench counter units: 1091 cycles after the accepting edge, +1 for the recording point

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         curWe = 1'b0;
  logic [2:0]   curRow = '0;
  logic [63:0]  curData = '0;
  logic         winWe = 1'b0;
  logic [5:0]   winRow = '0;
  logic [319:0] winData = '0;
  logic         start = 1'b0;
  logic         busy, done;
  logic [13:0]  bestSad;
  logic signed [5:0] mvX, mvY;

  me_fullsearch dut_i (
    .clk(clk), .rstN(rstN), .curWe(curWe), .curRow(curRow), .curData(curData),
    .winWe(winWe), .winRow(winRow), .winData(winData), .start(start),
    .busy(busy), .done(done), .bestSad(bestSad), .mvX(mvX), .mvY(mvY)
  );

  always #10 clk = ~clk; // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  int curPix [BLK][BLK];
  int winPix [WIN][WIN];

  typedef struct {
    int sad;
    int mx;
    int my;
    int startCyc;
    string tag;
  } expItem_t;

  expItem_t expQ [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] curWord(input int r);
    logic [63:0] w;
    for (int c = 0; c < BLK; c++) w[c*8 +: 8] = 8'(curPix[r][c]);
    return w;
  endfunction

  function automatic logic [319:0] winWord(input int r);
    logic [319:0] w;
    for (int c = 0; c < WIN; c++) w[c*8 +: 8] = 8'(winPix[r][c]);
    return w;
  endfunction

  function automatic void calcBest(output int bs, output int bx, output int by);
    bs = 1 << 30; bx = 0; by = 0;
    for (int dy = -RNG; dy <= RNG; dy++) begin
      for (int dx = -RNG; dx <= RNG; dx++) begin
        int s = 0;
        for (int r = 0; r < BLK; r++) begin
          for (int c = 0; c < BLK; c++) begin
            int a = curPix[r][c];
            int b = winPix[r+dy+RNG][c+dx+RNG];
            s += (a > b) ? a - b : b - a;
          end
        end
        if (s < bs) begin bs = s; bx = dx; by = dy; end
      end
    end
  endfunction

  task automatic loadCur();
    for (int r = 0; r < BLK; r++) begin
      @(negedge clk); curWe = 1'b1; curRow = 3'(r); curData = curWord(r);
    end
    @(negedge clk); curWe = 1'b0;
  endtask

  task automatic loadWin(input int lastRow);
    for (int r = 0; r <= lastRow; r++) begin
      @(negedge clk); winWe = 1'b1; winRow = 6'(r); winData = winWord(r);
    end
    @(negedge clk); winWe = 1'b0;
  endtask

  task automatic fillCur(input int mode);
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        curPix[r][c] = (mode < 0) ? ($urandom & 255) : mode;
  endtask

  task automatic fillWin(input int mode);
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++)
        winPix[r][c] = (mode < 0) ? ($urandom & 255) : mode;
  endtask

  task automatic plant(input int dx, input int dy);
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        winPix[r+dy+RNG][c+dx+RNG] = curPix[r][c];
  endtask

  // driver: pushes the expected result, then starts the search
  task automatic runSearch(input string tag, input bit disturb);
    expItem_t it;
    calcBest(it.sad, it.mx, it.my);
    it.tag = tag;
    @(negedge clk);
    it.startCyc = cyc;
    expQ.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", {tag, " busy after start"}, int'(busy), 1);
    if (disturb) begin
      repeat (20) @(negedge clk);
      start = 1'b1;                       // R7: must be ignored
      @(negedge clk);
      start = 1'b0;
      winWe = 1'b1; winRow = 6'd39; winData = '1;   // R8: must be ignored
      @(negedge clk);
      winWe = 1'b0;
      curWe = 1'b1; curRow = 3'd3; curData = ~curWord(3);
      @(negedge clk);
      curWe = 1'b0;
      check(busy == 1'b1, "R7", {tag, " busy during scan"}, int'(busy), 1);
    end
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    check(int'(bestSad) == it.sad, "R10", {tag, " bestSad held"}, int'(bestSad), it.sad);
    check(int'(mvX) == it.mx, "R10", {tag, " mvX held"}, int'(mvX), it.mx);
    check(int'(mvY) == it.my, "R10", {tag, " mvY held"}, int'(mvY), it.my);
  endtask

  // monitor: pops the expected item whenever a result strobe appears
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "unexpected done", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(int'(bestSad) == e.sad, "R3", {e.tag, " bestSad"}, int'(bestSad), e.sad);
        check(int'(mvX) == e.mx, "R4", {e.tag, " mvX"}, int'(mvX), e.mx);
        check(int'(mvY) == e.my, "R4", {e.tag, " mvY"}, int'(mvY), e.my);
        check(cyc - e.startCyc == LAT, "R6", {e.tag, " latency"}, cyc - e.startCyc, LAT);
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset values
    check(busy == 1'b0, "R11", "busy", int'(busy), 0);
    check(done == 1'b0, "R11", "done", int'(done), 0);
    check(int'(bestSad) == 16383, "R11", "bestSad", int'(bestSad), 16383);
    check(int'(mvX) == 0, "R11", "mvX", int'(mvX), 0);
    check(int'(mvY) == 0, "R11", "mvY", int'(mvY), 0);

    // R2: window row 39 missing, start must not begin a search
    fillCur(-1);
    fillWin(-1);
    loadCur();
    loadWin(38);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(busy == 1'b0, "R2", "busy with partial load", int'(busy), 0);
      @(negedge clk);
    end
    @(negedge clk); winWe = 1'b1; winRow = 6'd39; winData = winWord(39);
    @(negedge clk); winWe = 1'b0;

    // R3 R4 R6 R7 R8: random data with a start and writes injected while busy
    runSearch("random", 1'b1);
    // R8: stores untouched, same data gives the same answer again
    runSearch("reuse", 1'b0);

    // R1 R4: exact copy at dx=5, dy=-7
    fillCur(-1);
    fillWin(-1);
    plant(5, -7);
    loadCur();
    loadWin(WIN - 1);
    runSearch("planted", 1'b0);

    // R9: maximum SAD straight after a zero result
    fillCur(255);
    fillWin(0);
    loadCur();
    loadWin(WIN - 1);
    runSearch("maxsad", 1'b0);
    check(int'(bestSad) == 16320, "R9", "max SAD value", int'(bestSad), 16320);

    // R5: two exact copies, (3,2) comes first in raster order
    fillCur(-1);
    fillWin(-1);
    plant(-4, 5);
    plant(3, 2);
    loadCur();
    loadWin(WIN - 1);
    runSearch("tie_pair", 1'b0);
    check(int'(mvX) == 3 && int'(mvY) == 2, "R5", "tie keeps first dx", int'(mvX), 3);

    // R5: all offsets equal, first offset (-16,-16) wins
    fillCur(0);
    fillWin(0);
    loadCur();
    loadWin(WIN - 1);
    runSearch("all_equal", 1'b0);
    check(int'(mvX) == -16 && int'(mvY) == -16, "R5", "flat tie dy", int'(mvY), -16);

    // R1 R4: only match at the far corner (+16,+16)
    fillCur(0);
    fillWin(255);
    plant(16, 16);
    loadCur();
    loadWin(WIN - 1);
    runSearch("corner", 1'b0);

    check(expQ.size() == 0, "R6", "results outstanding", expQ.size(), 0);
    finishRun();
  end

endmodule